// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the master side of a read-only link to a serial EEPROM that shares a single bidirectional data pin between both directions. A host pulses a start strobe with an 8-bit word address. The reader raises chip select and begins toggling a divided serial clock. It shifts out a start bit, a two-bit read command and the address, then hands the data pin over to the memory. It drops one dummy bit and collects a 16-bit word, most significant bit first.

At the end of the frame chip select falls, and the word is presented on a registered output together with a single-cycle done flag. The pin is not instantiated as a tristate inside the block. Instead the block exposes a drive enable, a drive value and the sampled pin level, so that the pad can be placed at the chip edge.

Top module: `eeprom3w_reader`

## Requirements
- R1: While reset is high and after it is released with no request, cs, sck, sd_oe, busy and done are all 0.
- R2: sck is 0 whenever cs is 0. While cs is high, sck has a period of CLK_DIV system clocks with equal high and low halves. The first rising edge comes CLK_DIV/2 clocks after the clock edge that accepts the request.
- R3: sd_out is 1 (the start bit) from the edge that raises cs, so the first rising sck edge samples a 1.
- R4: sd_out changes only at the edge where sck falls, or where cs rises. The bits seen on rising sck edges 2 to 11 are the command 1 then 0, followed by the address MSB first.
- R5: sd_oe is high from the start of the frame and falls at the falling sck edge that follows the 11th rising edge. It then stays low to the end of the frame, so it never overlaps the memory's drive.
- R6: The line level captured before the 12th rising edge (the dummy bit) is discarded. The levels captured before rising edges 13 to 28 form the word, with the first of them as bit 15.
- R7: At the falling edge after the 28th rising edge, cs and busy fall, done is 1 for exactly one clock, and rdata takes the new word. This edge comes 28*CLK_DIV clocks after the accepting edge.
- R8: A start pulse while busy is high is ignored: the frame, its address and its result are unchanged.
- R9: rdata holds its last value until the next frame completes.
- R10: sd_oe is high only while cs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read request strobe, accepted only when idle |
| addr | input | ADDR_W | Word address captured with the request |
| busy | output | 1 | High for the duration of a frame |
| done | output | 1 | One-cycle pulse when rdata is updated |
| rdata | output | DATA_W | Last word read |
| cs | output | 1 | Chip select to the memory, active high |
| sck | output | 1 | Serial clock to the memory |
| sd_oe | output | 1 | Drive enable for the shared data pin |
| sd_out | output | 1 | Value driven onto the shared data pin |
| sd_in | input | 1 | Sampled level of the shared data pin |

## Verification
The bench builds the reader with CLK_DIV set to 6. This gives a half period of three clocks, so the divider counter wraps at a value that is not a power of two, and an off-by-one in the divider or edge timing shifts every expected sck transition. The address and data widths stay at 8 and 16. The memory model pulls the line high when nobody drives it, so a captured dummy bit or a one-bit slip in capture changes the returned word. One frame receives a second start pulse mid-frame with a different address to show that it is ignored.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
  localparam logic [1:0] READ_CMD = 2'b10;
  localparam int unsigned START_BITS = 1;
  localparam int unsigned CMD_BITS = 2;
  localparam int unsigned DUMMY_BITS = 1;
endpackage

// File: rtl/eeprom3w_sclk_gen.sv
module eeprom3w_sclk_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == CNT_LAST);
  assign rise_tick = tick && !sck;
  assign fall_tick = tick && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom3w_shift.sv
module eeprom3w_shift #(
  parameter int unsigned TX_W = 11,
  parameter int unsigned RX_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TX_W-1:0] load_val,
  input  logic            tx_adv,
  input  logic            rx_cap,
  input  logic            rx_bit,
  output logic            tx_bit,
  output logic [RX_W-1:0] rx_word
);
  logic [TX_W-1:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      tx_bit <= 1'b0;
    end else if (load) begin
      tx_bit <= load_val[TX_W-1];
      tx_sh  <= {load_val[TX_W-2:0], 1'b0};
    end else if (tx_adv) begin
      tx_bit <= tx_sh[TX_W-1];
      tx_sh  <= {tx_sh[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
    end else if (rx_cap) begin
      rx_word <= {rx_word[RX_W-2:0], rx_bit};
    end
  end
endmodule

// File: rtl/eeprom3w_reader.sv
module eeprom3w_reader
  import eeprom3w_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs,
  output logic              sck,
  output logic              sd_oe,
  output logic              sd_out,
  input  logic              sd_in
);
  localparam int unsigned HALF      = CLK_DIV / 2;
  localparam int unsigned TX_W      = START_BITS + CMD_BITS + ADDR_W;
  localparam int unsigned LAST_RISE = TX_W + DUMMY_BITS + DATA_W;
  localparam int unsigned RCW       = $clog2(LAST_RISE + 1);
  localparam logic [RCW-1:0] RC_TX_END = RCW'(TX_W);
  localparam logic [RCW-1:0] RC_RX_GO  = RCW'(TX_W + DUMMY_BITS);
  localparam logic [RCW-1:0] RC_LAST   = RCW'(LAST_RISE);

  seq_state_t        state;
  logic [RCW-1:0]    rise_cnt;
  logic              rise_tick, fall_tick;
  logic              accept, tx_adv, rx_cap;
  logic [TX_W-1:0]   frame_hdr;
  logic [DATA_W-1:0] rx_word;

  assign accept    = (state == SEQ_IDLE) && start;
  assign frame_hdr = {1'b1, READ_CMD, addr};
  assign tx_adv    = fall_tick && (rise_cnt < RC_TX_END);
  assign rx_cap    = rise_tick && (rise_cnt >= RC_RX_GO);

  eeprom3w_sclk_gen #(.HALF(HALF)) u_sclk (
    .clk       (clk),
    .rst       (rst),
    .run       (cs),
    .sck       (sck),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  eeprom3w_shift #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (frame_hdr),
    .tx_adv   (tx_adv),
    .rx_cap   (rx_cap),
    .rx_bit   (sd_in),
    .tx_bit   (sd_out),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      rise_cnt <= '0;
      cs       <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      sd_oe    <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            state    <= SEQ_RUN;
            rise_cnt <= '0;
            cs       <= 1'b1;
            busy     <= 1'b1;
            sd_oe    <= 1'b1;
          end
        end
        SEQ_RUN: begin
          if (rise_tick) begin
            rise_cnt <= rise_cnt + 1'b1;
          end
          if (fall_tick) begin
            if (rise_cnt == RC_TX_END) begin
              sd_oe <= 1'b0;
            end
            if (rise_cnt == RC_LAST) begin
              state <= SEQ_IDLE;
              cs    <= 1'b0;
              busy  <= 1'b0;
              done  <= 1'b1;
              rdata <= rx_word;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom3w_reader_chk.sv
module eeprom3w_reader_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs,
  input logic sck,
  input logic sd_oe,
  input logic sd_out
);
  // R2
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !sck);
  // R2 / R3: clock only rises inside an already-open frame
  a_r2_rise_inside_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> (cs && $past(cs)));
  // R4
  a_r4_out_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> (($past(sck) && !sck) || $rose(cs)));
  // R5
  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_oe) |-> $fell(sck));
  // R7
  a_r7_done_closes_frame: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cs && !busy && !sd_oe));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  a_r10_drive_inside_frame: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> cs);
endmodule

bind eeprom3w_reader eeprom3w_reader_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .cs     (cs),
  .sck    (sck),
  .sd_oe  (sd_oe),
  .sd_out (sd_out)
);

// File: tb/eeprom3w_reader_bench.sv
module eeprom3w_reader_bench;
  localparam int DIV  = 6;
  localparam int HALF = DIV / 2;
  localparam int TOGS = 56;
  localparam int NCYC = TOGS * HALF + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  addr = '0;
  logic        busy, done, cs, sck, sd_oe, sd_out;
  logic [15:0] rdata;
  wire         sd_line;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // Memory model state
  logic        m_en = 1'b0;
  logic        m_val = 1'b1;
  int          m_rc = 0;
  logic [10:0] m_rx = '0;
  logic [15:0] m_word = '0;

  assign sd_line = sd_oe ? sd_out : (m_en ? m_val : 1'b1);

  eeprom3w_reader #(.CLK_DIV(DIV), .ADDR_W(8), .DATA_W(16)) u_eeprom3w_reader (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .busy(busy), .done(done),
    .rdata(rdata), .cs(cs), .sck(sck), .sd_oe(sd_oe), .sd_out(sd_out), .sd_in(sd_line)
  );

  function automatic logic [15:0] word_of(input logic [7:0] a);
    return {~a, a ^ 8'hC3};
  endfunction

  always @(posedge sck or negedge sck or negedge cs) begin
    if (!cs) begin
      m_en = 1'b0;
      m_rc = 0;
    end else if (sck) begin
      m_rc = m_rc + 1;
      if (m_rc <= 11) m_rx = {m_rx[9:0], sd_line};
      if (m_rc == 11) m_word = word_of(m_rx[7:0]);
      if (m_rc >= 12 && m_rc <= 27) m_val = m_word[27 - m_rc];
    end else if (m_rc == 11) begin
      m_en  = 1'b1;
      m_val = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] last_word = '0;

  task automatic do_read(input logic [7:0] a, input bit intrude);
    @(negedge clk);
    start = 1'b1;
    addr  = a;
    for (int e = 1; e <= NCYC; e++) begin
      int  tog;
      bit  e_sck, e_cs, e_oe, e_done;
      @(negedge clk);
      if (e == 1) start = 1'b0;
      if (intrude && e == 20) begin start = 1'b1; addr = ~a; end
      if (intrude && e == 21) start = 1'b0;
      tog    = (e - 1) / HALF;
      e_cs   = (tog < TOGS);
      e_sck  = e_cs && (tog % 2 == 1);
      e_oe   = (tog < 22);
      e_done = (e == NCYC);
      chk(sck == e_sck, "R2", "sck", 32'(sck), 32'(e_sck));
      chk(cs == e_cs, "R7", "cs", 32'(cs), 32'(e_cs));
      chk(busy == e_cs, "R8", "busy", 32'(busy), 32'(e_cs));
      chk(sd_oe == e_oe, "R5", "sd_oe", 32'(sd_oe), 32'(e_oe));
      chk(!(sd_oe && m_en), "R5", "line contention", 32'(m_en), 32'd0);
      chk(!sd_oe || cs, "R10", "sd_oe outside frame", 32'(sd_oe), 32'(cs));
      chk(done == e_done, "R7", "done", 32'(done), 32'(e_done));
      if (e == 1)
        chk(sd_out == 1'b1, "R3", "start bit", 32'(sd_out), 32'd1);
      if (!e_done)
        chk(rdata == last_word, "R9", "rdata hold", 32'(rdata), 32'(last_word));
    end
    chk(rdata == word_of(a), "R6", "word", 32'(rdata), 32'(word_of(a)));
    chk(m_rx == {3'b110, a}, "R4", "header bits", 32'(m_rx), 32'({3'b110, a}));
    if (intrude)
      chk(rdata == word_of(a), "R8", "ignored restart", 32'(rdata), 32'(word_of(a)));
    last_word = word_of(a);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", 32'(done), 32'd0);
    chk(cs == 1'b0 && sck == 1'b0, "R2", "idle after frame", 32'({cs, sck}), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk({cs, sck, sd_oe, busy, done} == 5'b0, "R1", "in reset",
        32'({cs, sck, sd_oe, busy, done}), 32'd0);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk({cs, sck, sd_oe, busy, done} == 5'b0, "R1", "idle",
          32'({cs, sck, sd_oe, busy, done}), 32'd0);
    end
    do_read(8'h00, 1'b0);
    do_read(8'hFF, 1'b0);
    do_read(8'h5A, 1'b1);
    do_read(8'hA5, 1'b0);
    do_read(8'h81, 1'b0);
    repeat (7) begin
      @(negedge clk);
      chk(rdata == last_word, "R9", "rdata idle hold", 32'(rdata), 32'(last_word));
    end
    do_read(8'h3C, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule